// File: doc/BRIEF.md
# Tagged Reservation Stations with Result Broadcast

This block schedules arithmetic operations out of order while accepting them strictly in program order. It holds five reservation stations: three serve an add/subtract unit and two serve a multiply/divide unit. Each station has its own countdown timer that models the execution latency. Next to the stations sits a register file and a rename table. The rename table records, for every architectural register, which station will produce its next value. An instruction is accepted whenever a station of the right class is free. Each of its two sources is captured as a value, or as the tag of the station that will produce it. The destination register is then renamed to the accepting station, so neither write-after-read nor write-after-write hazards ever hold up acceptance.

Finished stations compete for a single result bus that carries a 4-bit producer tag and a 64-bit value. One result is broadcast per cycle, and the station that has been waiting longest wins. The broadcast frees the winning station. It fills every waiting operand that carries the matching tag, and it updates the register file only where the rename table still names that producer. A registered copy of the bus is driven on the outputs. A read port returns one register's value together with its pending producer tag.

Top module: `rs_rename_core`

## Requirements
- R1: After reset all stations are free, the bus outputs are idle, every rename entry is 0, and register r holds the value r+1.
- R2: Operation codes are 0 add, 1 subtract, 2 multiply and 3 divide. `iss_ready` is high exactly when a station of the class selected by `iss_op` is free. Add and subtract take tags 1..3, multiply and divide take tags 4..5, and the lowest free tag of the class is used. An accepted instruction occupies one more station.
- R3: One cycle after an instruction is accepted, the rename entry of its destination holds the accepting station's tag, even if an older producer of that register is still pending.
- R4: Sources are captured at acceptance, so a later instruction that overwrites a source register changes nothing for an earlier reader. Acceptance never waits on register hazards.
- R5: A station whose operands are ready at acceptance counts 2 cycles for add or subtract, 10 for multiply and 40 for divide. Its result appears on `bus_valid`/`bus_tag`/`bus_data` 3, 11 or 41 clock edges after the accepting edge, when the bus is uncontested.
- R6: Results are the 64-bit wrapped sum, the wrapped difference (first minus second source), the low 64 bits of the product, and the unsigned quotient. A zero divisor gives all ones.
- R7: At most one result is broadcast per cycle. The broadcasting station is freed, and every station waiting on that tag captures the value.
- R8: When several stations are finished in the same cycle, the one accepted earliest broadcasts first. The others keep their results and follow in later cycles.
- R9: A broadcast writes a register and clears its rename entry only if that entry still holds the broadcast tag. A superseded producer leaves the register untouched.
- R10: An instruction accepted in the same cycle as the broadcast of a tag it needs takes the broadcast value directly and does not wait for that tag again.
- R11: Once all work has drained, the register file equals the result of executing the accepted instructions one at a time in program order.
- R12: `rf_rdata` and `rf_rtag` show the value and rename entry of register `rf_raddr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction offered by the in-order operation queue |
| iss_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 div) |
| iss_dst | input | $clog2(NREG) | Destination register |
| iss_src1 | input | $clog2(NREG) | First source register |
| iss_src2 | input | $clog2(NREG) | Second source register |
| iss_ready | output | 1 | A station of the class of `iss_op` is free |
| bus_valid | output | 1 | Registered copy of the result bus: broadcast present |
| bus_tag | output | TAG_W | Registered copy of the broadcasting station tag |
| bus_data | output | DW | Registered copy of the broadcast value |
| rf_raddr | input | $clog2(NREG) | Register read address |
| rf_rdata | output | DW | Registered value of the addressed register |
| rf_rtag | output | TAG_W | Registered rename entry of the addressed register |

## Verification
Isolated instructions on an empty core pin down each latency, the tag each class uses and the arithmetic, including a wrapping subtraction and a zero divisor. Dependent chains are used in three ways. A long divide feeding several adds fills one station class while the other stays open. A multiply overtaken by a younger write to the same register shows that a stale producer cannot overwrite a newer value. An add accepted in the very cycle its producer broadcasts catches a missed wakeup, which would leave the core hung. Two adds woken by the same broadcast, where the older one sits in the higher-numbered station, separate age order from index order. Seeded random programs then compare the drained register file against sequential execution.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } rs_op_e;

endpackage

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int DW    = 64,
  parameter int TAG_W = 4,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  rs_op_e           a_op,
  input  logic [DW-1:0]    a_vj,
  input  logic [TAG_W-1:0] a_qj,
  input  logic [DW-1:0]    a_vk,
  input  logic [TAG_W-1:0] a_qk,
  input  logic [CW-1:0]    a_lat,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  input  logic [DW-1:0]    bc_data,
  input  logic             grant,
  output logic             busy,
  output logic             done,
  output rs_op_e           op,
  output logic [DW-1:0]    vj,
  output logic [DW-1:0]    vk
);

  logic [TAG_W-1:0] qj, qk;
  logic [CW-1:0]    cnt;
  logic             ops_ready;

  assign ops_ready = (qj == '0) && (qk == '0);
  assign done      = busy && ops_ready && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      op   <= OP_ADD;
      vj   <= '0;
      vk   <= '0;
      qj   <= '0;
      qk   <= '0;
      cnt  <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      op   <= a_op;
      vj   <= a_vj;
      vk   <= a_vk;
      qj   <= a_qj;
      qk   <= a_qk;
      cnt  <= a_lat;
    end else begin
      if (grant) busy <= 1'b0;
      if (busy && qj != '0 && bc_valid && bc_tag == qj) begin
        vj <= bc_data;
        qj <= '0;
      end
      if (busy && qk != '0 && bc_valid && bc_tag == qk) begin
        vk <= bc_data;
        qk <= '0;
      end
      if (busy && ops_ready && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rs_age_arbiter.sv
module rs_age_arbiter #(
  parameter int NS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] alloc,
  input  logic [NS-1:0] done,
  output logic [NS-1:0] grant
);

  // older_q[a][b] set: station a was accepted before station b
  logic [NS-1:0] older_q [NS];
  logic [NS-1:0] blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < NS; k++) begin
        if (alloc[k]) begin
          for (int j = 0; j < NS; j++) begin
            older_q[k][j] <= 1'b0;
            if (j != k) older_q[j][k] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < NS; j++) begin
        if (j != i && done[j] && older_q[j][i]) blocked[i] = 1'b1;
      end
      grant[i] = done[i] && !blocked[i];
    end
  end

endmodule

// File: rtl/rs_alu.sv
module rs_alu
  import rs_pkg::*;
#(
  parameter int DW = 64
) (
  input  rs_op_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      default: y = (b == '0) ? '1 : a / b;
    endcase
  end

endmodule

// File: rtl/rs_rename_core.sv
module rs_rename_core
  import rs_pkg::*;
#(
  parameter int DW      = 64,
  parameter int NREG    = 8,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int TAG_W   = 4,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 10,
  parameter int DIV_LAT = 40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      iss_valid,
  input  logic [1:0]                iss_op,
  input  logic [$clog2(NREG)-1:0]   iss_dst,
  input  logic [$clog2(NREG)-1:0]   iss_src1,
  input  logic [$clog2(NREG)-1:0]   iss_src2,
  output logic                      iss_ready,
  output logic                      bus_valid,
  output logic [TAG_W-1:0]          bus_tag,
  output logic [DW-1:0]             bus_data,
  input  logic [$clog2(NREG)-1:0]   rf_raddr,
  output logic [DW-1:0]             rf_rdata,
  output logic [TAG_W-1:0]          rf_rtag
);

  localparam int NS   = N_ADD + N_MUL;
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1;
  localparam int RW   = $clog2(NREG);
  localparam int LM1  = (MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT;
  localparam int LMAX = (DIV_LAT > LM1) ? DIV_LAT : LM1;
  localparam int CW   = $clog2(LMAX + 1);

  rs_op_e           iss_op_e;
  logic             iss_long;
  logic             found;
  logic [SW-1:0]    pick;
  logic             iss_fire;
  logic [NS-1:0]    alloc_v;
  logic [TAG_W-1:0] alloc_tag;
  logic [CW-1:0]    alloc_lat;

  logic [NS-1:0]    busy_v, done_v, grant_v;
  rs_op_e           st_op [NS];
  logic [DW-1:0]    st_vj [NS];
  logic [DW-1:0]    st_vk [NS];

  logic             bc_valid;
  logic [TAG_W-1:0] bc_tag;
  logic [DW-1:0]    bc_data;
  logic [SW-1:0]    win;

  logic [TAG_W-1:0] stat_q [NREG];
  logic [DW-1:0]    rf_q   [NREG];

  logic [DW-1:0]    sv [2];
  logic [TAG_W-1:0] sq [2];

  assign iss_op_e = rs_op_e'(iss_op);
  assign iss_long = iss_op[1];

  // lowest free station of the requested class
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (!busy_v[s] && ((s >= N_ADD) == iss_long)) begin
        found = 1'b1;
        pick  = SW'(s);
      end
    end
  end

  assign iss_ready = found;
  assign iss_fire  = iss_valid && found;
  assign alloc_v   = iss_fire ? (NS'(1) << pick) : '0;
  assign alloc_tag = TAG_W'(pick) + TAG_W'(1);

  always_comb begin
    unique case (iss_op_e)
      OP_ADD, OP_SUB: alloc_lat = CW'(ADD_LAT);
      OP_MUL:         alloc_lat = CW'(MUL_LAT);
      default:        alloc_lat = CW'(DIV_LAT);
    endcase
  end

  // operand capture: register value, same-cycle broadcast, or producer tag
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      logic [RW-1:0]    sel;
      logic [TAG_W-1:0] st;
      sel = (k == 0) ? iss_src1 : iss_src2;
      st  = stat_q[sel];
      if (st == '0) begin
        sv[k] = rf_q[sel];
        sq[k] = '0;
      end else if (bc_valid && bc_tag == st) begin
        sv[k] = bc_data;
        sq[k] = '0;
      end else begin
        sv[k] = '0;
        sq[k] = st;
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_st
    rs_station #(
      .DW(DW), .TAG_W(TAG_W), .CW(CW)
    ) u_st (
      .clk      (clk),
      .rst      (rst),
      .alloc    (alloc_v[s]),
      .a_op     (iss_op_e),
      .a_vj     (sv[0]),
      .a_qj     (sq[0]),
      .a_vk     (sv[1]),
      .a_qk     (sq[1]),
      .a_lat    (alloc_lat),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .grant    (grant_v[s]),
      .busy     (busy_v[s]),
      .done     (done_v[s]),
      .op       (st_op[s]),
      .vj       (st_vj[s]),
      .vk       (st_vk[s])
    );
  end

  rs_age_arbiter #(.NS(NS)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .alloc (alloc_v),
    .done  (done_v),
    .grant (grant_v)
  );

  always_comb begin
    win = '0;
    for (int s = 0; s < NS; s++) begin
      if (grant_v[s]) win = SW'(s);
    end
  end

  assign bc_valid = |grant_v;
  assign bc_tag   = TAG_W'(win) + TAG_W'(1);

  rs_alu #(.DW(DW)) u_alu (
    .op (st_op[win]),
    .a  (st_vj[win]),
    .b  (st_vk[win]),
    .y  (bc_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) begin
        stat_q[r] <= '0;
        rf_q[r]   <= DW'(r + 1);
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (bc_valid && stat_q[r] == bc_tag) begin
          rf_q[r]   <= bc_data;
          stat_q[r] <= '0;
        end
      end
      if (iss_fire) stat_q[iss_dst] <= alloc_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_tag   <= '0;
      bus_data  <= '0;
      rf_rdata  <= '0;
      rf_rtag   <= '0;
    end else begin
      bus_valid <= bc_valid;
      bus_tag   <= bc_valid ? bc_tag : '0;
      bus_data  <= bc_valid ? bc_data : '0;
      rf_rdata  <= rf_q[rf_raddr];
      rf_rtag   <= stat_q[rf_raddr];
    end
  end

endmodule

// File: rtl/rs_rename_core_chk.sv
module rs_rename_core_chk #(
  parameter int NS    = 5,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_fire,
  input logic             bc_valid,
  input logic [TAG_W-1:0] bc_tag,
  input logic             bus_valid,
  input logic [TAG_W-1:0] bus_tag,
  input logic [NS-1:0]    busy_v,
  input logic [NS-1:0]    done_v,
  input logic [NS-1:0]    grant_v
);

  assert_accept_occupies_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_fire && grant_v == '0) |=> ($countones(busy_v) == $countones($past(busy_v)) + 1));

  assert_bus_tag_range_R2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_tag != '0 && int'(bus_tag) <= NS));

  assert_bus_latch_R5: assert property (@(posedge clk) disable iff (rst)
    bc_valid |=> (bus_valid && bus_tag == $past(bc_tag)));

  assert_single_winner_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_v));

  assert_grant_finished_R7: assert property (@(posedge clk) disable iff (rst)
    ((grant_v & ~done_v) == '0));

  assert_winner_freed_R7: assert property (@(posedge clk) disable iff (rst)
    (grant_v != '0) |=> ((busy_v & $past(grant_v)) == '0));

  assert_bus_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !bc_valid |=> !bus_valid);

endmodule

bind rs_rename_core rs_rename_core_chk #(.NS(NS), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iss_fire  (iss_fire),
  .bc_valid  (bc_valid),
  .bc_tag    (bc_tag),
  .bus_valid (bus_valid),
  .bus_tag   (bus_tag),
  .busy_v    (busy_v),
  .done_v    (done_v),
  .grant_v   (grant_v)
);

// File: tb/rs_rename_core_tb.sv
module rs_rename_core_tb;

  localparam int DW = 64;
  localparam int NREG = 8;
  localparam int RW = 3;
  localparam int TW = 4;
  localparam logic [1:0] OA = 2'd0, OS = 2'd1, OM = 2'd2, OD = 2'd3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 1'b0;
  logic [1:0]    iss_op = 2'd0;
  logic [RW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0, rf_raddr = '0;
  logic          iss_ready, bus_valid;
  logic [TW-1:0] bus_tag, rf_rtag;
  logic [DW-1:0] bus_data, rf_rdata;

  always #10 clk = ~clk;

  rs_rename_core u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .bus_valid(bus_valid), .bus_tag(bus_tag),
    .bus_data(bus_data), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_rtag(rf_rtag)
  );

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] mdl [NREG];

  int cyc = 0;
  int log_n = 0;
  logic [TW-1:0] log_tag [64];
  logic [DW-1:0] log_data [64];
  int log_cyc [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && bus_valid && log_n < 64) begin
      log_tag[log_n]  <= bus_tag;
      log_data[log_n] <= bus_data;
      log_cyc[log_n]  <= cyc;
      log_n <= log_n + 1;
    end
  end

  function automatic logic [DW-1:0] ref_op(input logic [1:0] op, input logic [DW-1:0] a, b);
    case (op)
      OA: return a + b;
      OS: return a - b;
      OM: return a * b;
      default: return (b == 0) ? {DW{1'b1}} : a / b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // called at a negative edge; returns at the negative edge after acceptance
  task automatic do_issue(input logic [1:0] op, input int dst, a, b, output int waited);
    iss_op = op; iss_dst = RW'(dst); iss_src1 = RW'(a); iss_src2 = RW'(b);
    iss_valid = 1'b1;
    waited = 0;
    #1;
    while (!iss_ready) begin
      @(negedge clk); #1;
      waited++;
    end
    @(posedge clk);
    mdl[dst] = ref_op(op, mdl[a], mdl[b]);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic rd_reg(input int r, output logic [DW-1:0] d, output logic [TW-1:0] t);
    rf_raddr = RW'(r);
    @(posedge clk);
    @(negedge clk);
    d = rf_rdata;
    t = rf_rtag;
  endtask

  task automatic drain();
    repeat (260) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [DW-1:0] d;
    logic [TW-1:0] t;
    for (int r = 0; r < NREG; r++) begin
      rd_reg(r, d, t);
      check(d == mdl[r], req, d, mdl[r]);
      check(t == 0, req, DW'(t), 0);
    end
  endtask

  task automatic measure(input logic [1:0] op, input int dst, a, b, input int exp_k,
                         input int exp_tag, input string req);
    int w;
    int found;
    found = 0;
    do_issue(op, dst, a, b, w);
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (bus_valid) begin
        found = k;
        break;
      end
    end
    check(found == exp_k, req, DW'(found), DW'(exp_k));
    check(bus_tag == TW'(exp_tag), req, DW'(bus_tag), DW'(exp_tag));
    check(bus_data == mdl[dst], "R6", bus_data, mdl[dst]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    int w;
    int base;
    logic [DW-1:0] d;
    logic [TW-1:0] t;
    bit seen;
    for (int r = 0; r < NREG; r++) mdl[r] = DW'(r + 1);
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, read port (R12)
    check(bus_valid == 1'b0, "R1", DW'(bus_valid), 0);
    iss_op = OA; #1;
    check(iss_ready == 1'b1, "R2", DW'(iss_ready), 1);
    iss_op = OD; #1;
    check(iss_ready == 1'b1, "R2", DW'(iss_ready), 1);
    check_all("R1_R12");

    // R5/R6: latencies and arithmetic on an idle core
    measure(OA, 1, 2, 3, 3, 1, "R5 add");
    repeat (3) @(negedge clk);
    measure(OS, 2, 1, 7, 3, 1, "R5 sub");
    repeat (3) @(negedge clk);
    measure(OM, 3, 4, 5, 11, 4, "R5 mul");
    repeat (3) @(negedge clk);
    measure(OD, 4, 3, 1, 41, 4, "R5 div");
    repeat (3) @(negedge clk);
    do_issue(OS, 0, 0, 0, w);
    do_issue(OD, 6, 5, 0, w);
    drain();
    check(mdl[6] == {DW{1'b1}}, "R6 model", mdl[6], {DW{1'b1}});
    check_all("R6");

    // R3/R9: renaming, stale producer must not overwrite
    base = log_n;
    do_issue(OM, 5, 1, 5, w);
    rd_reg(5, d, t);
    check(t == 4, "R3", DW'(t), 4);
    do_issue(OA, 5, 1, 1, w);
    rd_reg(5, d, t);
    check(t == 1, "R3", DW'(t), 1);
    drain();
    seen = 0;
    for (int i = base; i < log_n; i++) if (log_tag[i] == 4) seen = 1;
    check(seen, "R9 mul broadcast seen", DW'(seen), 1);
    check_all("R9");

    // R4: WAR / WAW never stall, sources captured at acceptance
    do_issue(OD, 1, 7, 5, w);
    do_issue(OA, 4, 1, 2, w);
    do_issue(OA, 2, 6, 6, w);
    check(w == 0, "R4 no stall WAR", DW'(w), 0);
    do_issue(OA, 1, 3, 3, w);
    check(w == 0, "R4 no stall WAW", DW'(w), 0);
    rd_reg(1, d, t);
    check(t == 3, "R3 newest producer", DW'(t), 3);
    drain();
    check_all("R4");

    // R2: one class full while the other is open
    do_issue(OD, 0, 7, 6, w);
    do_issue(OA, 1, 0, 0, w);
    do_issue(OA, 2, 0, 1, w);
    do_issue(OA, 3, 0, 0, w);
    iss_op = OA; #1;
    check(iss_ready == 1'b0, "R2 add class full", DW'(iss_ready), 0);
    iss_op = OM; #1;
    check(iss_ready == 1'b1, "R2 mul class open", DW'(iss_ready), 1);
    drain();
    check_all("R2");

    // R10: accept in the very cycle the producer broadcasts
    do_issue(OM, 5, 6, 7, w);
    repeat (10) @(negedge clk);
    do_issue(OA, 4, 5, 2, w);
    drain();
    check_all("R10");

    // R8: older waiter sits in the higher-numbered station
    base = log_n;
    do_issue(OM, 1, 2, 3, w);
    do_issue(OA, 6, 7, 7, w);
    do_issue(OA, 4, 1, 2, w);
    repeat (5) @(negedge clk);
    do_issue(OA, 5, 1, 3, w);
    drain();
    check(log_n - base == 4, "R8 event count", DW'(log_n - base), 4);
    check(log_tag[base+1] == 4, "R8 producer", DW'(log_tag[base+1]), 4);
    check(log_tag[base+2] == 2, "R8 oldest first", DW'(log_tag[base+2]), 2);
    check(log_tag[base+3] == 1, "R8 younger next", DW'(log_tag[base+3]), 1);
    check(log_cyc[base+3] == log_cyc[base+2] + 1, "R8 back to back",
          DW'(log_cyc[base+3]), DW'(log_cyc[base+2] + 1));
    check(log_data[base+2] == mdl[4], "R7 data", log_data[base+2], mdl[4]);
    check(log_data[base+3] == mdl[5], "R7 data", log_data[base+3], mdl[5]);
    check_all("R8");

    // R11: random programs against sequential execution
    for (int bt = 0; bt < 3; bt++) begin
      for (int n = 0; n < 30; n++) begin
        int sel;
        logic [1:0] op;
        sel = int'($urandom_range(0, 99));
        op = (sel < 35) ? OA : (sel < 70) ? OS : (sel < 90) ? OM : OD;
        do_issue(op, int'($urandom_range(0, NREG-1)), int'($urandom_range(0, NREG-1)),
                 int'($urandom_range(0, NREG-1)), w);
      end
      drain();
      check_all("R11");
    end

    finish_run();
  end

endmodule